// File: doc/BRIEF.md
# Four-Bank Flow-Through Synchronous Word RAM

This block is a synthesizable model of a static RAM split into four banks of 32-bit words. Each bank has its own active-low select line. On every rising clock edge the block captures the address, the four select lines, a global active-low write strobe and the write data. A write puts the word into the array at that same edge. A read registers its address and bank at the edge, and the stored word then flows combinationally from the array to the output. No output register sits on that path, so the data belongs to the cycle that directly follows the capturing edge.

The shared data bus is split into an input word, an output word and a drive-enable flag. A pad wrapper can join them into a tri-state bus. Two controls gate the output drive without using the clock: an active-low output enable and an active-high sleep input. Bank depth is set by the address-width parameter. The default is small for simulation, and a 17-bit address gives the full 128K words per bank.

Top module: `banked_ssram`

## Requirements
- R1: While reset is held and after it is released, the block does not drive the bus (`drive_en` = 0) and `rdata` reads 0 until a read cycle has been captured. Whenever `drive_en` is 0, `rdata` is all zeros.
- R2: An edge with exactly one `bank_en_n` bit low and `wr_n` low stores `wdata` at `addr` in the selected bank. Bit i of `bank_en_n` selects bank i. In the cycle after that edge `drive_en` is 0.
- R3: An edge with exactly one `bank_en_n` bit low and `wr_n` high is a read. In the cycle after that edge, with `oe_n` = 0 and `sleep` = 0, `drive_en` is 1 and `rdata` equals the word stored at the captured bank and address. There is no further clock of latency.
- R4: Reads captured on consecutive edges return their own words on consecutive cycles.
- R5: `oe_n` acts without the clock. Raising it inside a read cycle drops `drive_en` to 0 at once. Lowering it again within the same cycle restores the read word.
- R6: While `sleep` is 1, `drive_en` is 0 whatever the other inputs are.
- R7: An edge with all `bank_en_n` bits high is a deselect. No array word changes, even with `wr_n` low, and the following cycle is not driven.
- R8: An edge with two or more `bank_en_n` bits low is treated as a deselect. Nothing is written and the following cycle is not driven.
- R9: The banks are independent. The same address in different banks holds different words.
- R10: A read of an address on the edge right after a write to it returns the new word.
- R11: Input changes between edges do not affect the current cycle. Changing `addr` in the middle of a read cycle leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock; all captures happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the captured cycle state |
| addr | input | ADDR_W | Word address inside a bank |
| bank_en_n | input | 4 | Active-low bank selects; bit i selects bank i |
| wr_n | input | 1 | Active-low global write strobe |
| oe_n | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Forces the bus undriven while high |
| wdata | input | 32 | Write word, bytes in lanes [7:0] to [31:24] |
| rdata | output | 32 | Read word; zero when not driving |
| drive_en | output | 1 | High when the bus pad should drive `rdata` |

## Verification
A wrong captured bank index or address shows as a wrong `rdata` word in the very cycle after the read edge, because no register sits between the array and the port. A write decoded into the wrong bank, or a write that should have been suppressed, stays hidden until that location is read again. The bench therefore reads every location it has written and compares the result with a behavioural model. A stuck read flag shows as `drive_en` high after a write or deselect edge within one cycle. Gating faults on `oe_n` or `sleep` show within a fraction of a cycle, with no edge involved.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int WORD_W     = 32;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  typedef struct packed {
    logic                  hit;
    logic [BANK_IDX_W-1:0] idx;
  } bank_sel_t;

  // Exactly one low select gives a hit; zero or several give a deselect.
  function automatic bank_sel_t decode_selects(input logic [NUM_BANKS-1:0] sel_n);
    bank_sel_t r;
    int        lows;
    r    = '0;
    lows = 0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!sel_n[b]) begin
        lows  = lows + 1;
        r.idx = BANK_IDX_W'(b);
      end
    end
    r.hit = (lows == 1);
    if (!r.hit) r.idx = '0;
    return r;
  endfunction
endpackage

// File: rtl/ssram_cycle_reg.sv
module ssram_cycle_reg
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BANKS-1:0]  bank_en_n,
  input  logic                  wr_n,
  output logic                  cyc_write,
  output logic [BANK_IDX_W-1:0] wr_idx,
  output logic                  rd_q,
  output logic [BANK_IDX_W-1:0] rd_idx_q,
  output logic [ADDR_W-1:0]     rd_addr_q
);
  bank_sel_t sel;

  always_comb begin
    sel       = decode_selects(bank_en_n);
    cyc_write = sel.hit & ~wr_n;
    wr_idx    = sel.idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      rd_idx_q  <= '0;
      rd_addr_q <= '0;
    end else begin
      rd_q      <= sel.hit & wr_n;
      rd_idx_q  <= sel.idx;
      rd_addr_q <= addr;
    end
  end
endmodule

// File: rtl/ssram_bank_array.sv
module ssram_bank_array
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  cyc_write,
  input  logic [BANK_IDX_W-1:0] wr_idx,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [BANK_IDX_W-1:0] rd_idx,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [WORD_W-1:0]     rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] bank_word [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic              bank_we;

    assign bank_we = cyc_write && (wr_idx == BANK_IDX_W'(b));

    // Early write: word and address are taken at the same edge.
    always_ff @(posedge clk) begin
      if (bank_we) mem[wr_addr] <= wdata;
    end

    // Flow-through read from the captured address.
    assign bank_word[b] = mem[rd_addr];
  end

  assign rd_word = bank_word[rd_idx];
endmodule

// File: rtl/ssram_out_gate.sv
module ssram_out_gate
  import ssram_pkg::*;
(
  input  logic              rd_q,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] rd_word,
  output logic              drive_en,
  output logic [WORD_W-1:0] rdata
);
  always_comb begin
    drive_en = rd_q & ~oe_n & ~sleep;
    rdata    = drive_en ? rd_word : '0;
  end
endmodule

// File: rtl/banked_ssram.sv
module banked_ssram
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bank_en_n,
  input  logic                 wr_n,
  input  logic                 oe_n,
  input  logic                 sleep,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 drive_en
);
  logic                  cyc_write;
  logic [BANK_IDX_W-1:0] wr_idx;
  logic                  rd_q;
  logic [BANK_IDX_W-1:0] rd_idx_q;
  logic [ADDR_W-1:0]     rd_addr_q;
  logic [WORD_W-1:0]     rd_word;

  ssram_cycle_reg #(.ADDR_W(ADDR_W)) u_cycle (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .bank_en_n (bank_en_n),
    .wr_n      (wr_n),
    .cyc_write (cyc_write),
    .wr_idx    (wr_idx),
    .rd_q      (rd_q),
    .rd_idx_q  (rd_idx_q),
    .rd_addr_q (rd_addr_q)
  );

  ssram_bank_array #(.ADDR_W(ADDR_W)) u_array (
    .clk       (clk),
    .cyc_write (cyc_write),
    .wr_idx    (wr_idx),
    .wr_addr   (addr),
    .wdata     (wdata),
    .rd_idx    (rd_idx_q),
    .rd_addr   (rd_addr_q),
    .rd_word   (rd_word)
  );

  ssram_out_gate u_gate (
    .rd_q     (rd_q),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .rd_word  (rd_word),
    .drive_en (drive_en),
    .rdata    (rdata)
  );
endmodule

// File: rtl/banked_ssram_chk.sv
module banked_ssram_chk
  import ssram_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bank_en_n,
  input logic                 wr_n,
  input logic                 oe_n,
  input logic                 sleep,
  input logic                 cyc_write,
  input logic [WORD_W-1:0]    rdata,
  input logic                 drive_en
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (rdata == '0));

  assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_write |=> !drive_en);

  assert_oe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive_en);

  assert_sleep_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !drive_en);

  assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en_n == '1) |=> !drive_en);

  assert_multi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~bank_en_n) > 1) |=> !drive_en);

  assert_multi_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~bank_en_n) != 1) |-> !cyc_write);

  assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~bank_en_n) == 1 && wr_n) |=> (drive_en || oe_n || sleep));
endmodule

bind banked_ssram banked_ssram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bank_en_n (bank_en_n),
  .wr_n      (wr_n),
  .oe_n      (oe_n),
  .sleep     (sleep),
  .cyc_write (cyc_write),
  .rdata     (rdata),
  .drive_en  (drive_en)
);

// File: tb/banked_ssram_tb.sv
`timescale 1ns/1ps
module banked_ssram_tb;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] addr;
  logic [3:0]  bank_en_n;
  logic        wr_n, oe_n, sleep;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        drive_en;

  int errors = 0;
  int checks = 0;

  // behavioural reference
  logic [31:0] ref_mem [4][1 << AW];
  bit          ref_rd;
  int          ref_bank, ref_addr;

  always #2.5 clk = ~clk;

  banked_ssram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bank_en_n(bank_en_n),
    .wr_n(wr_n), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .drive_en(drive_en)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit          e_drv;
    logic [31:0] e_dat;
    e_drv = ref_rd && !oe_n && !sleep;
    e_dat = e_drv ? ref_mem[ref_bank][ref_addr] : 32'h0;
    check(tag, "drive_en", {31'h0, drive_en}, {31'h0, e_drv});
    check(tag, "rdata", rdata, e_dat);
  endtask

  // one clock: drive inputs, model the edge, compare at the falling edge
  task automatic step(input logic [3:0] en, input logic w, input int a,
                      input logic [31:0] d, input string tag);
    int lows, idx;
    bank_en_n = en; wr_n = w; addr = AW'(a); wdata = d;
    @(posedge clk);
    lows = 0; idx = 0;
    for (int b = 0; b < 4; b++) if (!en[b]) begin lows++; idx = b; end
    if (lows == 1 && !w) begin
      ref_mem[idx][a] = d;
      ref_rd = 0;
    end else if (lows == 1) begin
      ref_rd = 1; ref_bank = idx; ref_addr = a;
    end else begin
      ref_rd = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bank_en_n = 4'hF; wr_n = 1'b1; oe_n = 1'b0; sleep = 1'b0;
    addr = '0; wdata = '0; ref_rd = 0; ref_bank = 0; ref_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    step(4'hF, 1'b1, 0, 0, "R1 after reset");

    // R2 / R9: same address, four banks, distinct words
    for (int b = 0; b < 4; b++)
      step(~(4'h1 << b), 1'b0, 5, 32'hA000_0000 + b * 32'h0111_1111, "R2 write");
    for (int b = 0; b < 4; b++)
      step(~(4'h1 << b), 1'b1, 5, 0, "R9 bank read");

    // R4: fill and read back-to-back
    for (int a = 0; a < 8; a++) step(4'hD, 1'b0, a + 10, 32'h5000_0000 + a * 7, "R2 fill");
    for (int a = 0; a < 8; a++) step(4'hD, 1'b1, a + 10, 0, "R4 back-to-back");

    // R10: write then read at the next edge
    step(4'h7, 1'b0, 63, 32'hDEAD_BEEF, "R10 write");
    step(4'h7, 1'b1, 63, 0, "R10 read");
    step(4'h7, 1'b0, 63, 32'h1234_5678, "R10 overwrite");
    step(4'h7, 1'b1, 63, 0, "R10 reread");

    // R7: deselect with write strobe low leaves word intact
    step(4'hF, 1'b0, 5, 32'hFFFF_0000, "R7 deselect write");
    step(4'hE, 1'b1, 5, 0, "R7 readback");

    // R8: two or three selects low: no write, no drive
    step(4'hC, 1'b0, 5, 32'h0BAD_0BAD, "R8 multi write");
    step(4'h8, 1'b1, 5, 0, "R8 multi read");
    step(4'hE, 1'b1, 5, 0, "R8 readback b0");
    step(4'hD, 1'b1, 5, 0, "R8 readback b1");

    // R3 + R5 + R11 inside one read cycle
    step(4'hB, 1'b1, 5, 0, "R3 read");
    addr = AW'(11); #0.5;
    compare("R11 addr change mid-cycle");
    oe_n = 1'b1; #0.5;
    compare("R5 oe high");
    oe_n = 1'b0; #0.5;
    compare("R5 oe low again");

    // R6: sleep blocks the bus during a read
    sleep = 1'b1;
    step(4'hB, 1'b1, 5, 0, "R6 sleep read");
    step(4'hE, 1'b1, 10, 0, "R6 sleep read2");
    sleep = 1'b0; #0.5;
    compare("R6 sleep released");
    step(4'hF, 1'b1, 0, 0, "R7 idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule